// File: doc/BRIEF.md
# Paired Mixed-Sign Byte Dot-Product Unit

This block is a packed arithmetic helper for dot-product kernels. Each byte lane of operand A is read as an unsigned 8-bit number and is multiplied by the byte in the same lane of operand B, which is read as a signed 8-bit number. The two products of every adjacent lane pair are then summed. Each sum is clamped to the signed 16-bit range and packed into one output word, and a per-word flag records whether clamping took place.

A mode input selects the operand width. In wide mode all 128 operand bits are used and eight words come out. In narrow mode only the low 64 bits are used and four words come out. The unused upper half of the result reads as zero. Operations enter with a valid strobe and leave with a matching valid strobe. The unit accepts one operation per cycle. A parameter selects either a single register stage or two stages, where the products are registered before the sum and clamp.

Top module: `mixdot_pair_unit`

## Requirements
- R1: For byte lane i (operand bits 8i+7..8i), the lane product is the value of A's byte read as unsigned (0..255) times the value of B's byte read as two's-complement signed (-128..127).
- R2: Result word k (bits 16k+15..16k) equals the product of lane 2k plus the product of lane 2k+1, written in two's complement, whenever that sum lies in -32768..32767.
- R3: A pair sum above 32767 produces 16'h7FFF, and a pair sum below -32768 produces 16'h8000.
- R4: Flag bit k of out_sat is 1 exactly when word k of that result was clamped. A sum of exactly 32767 or exactly -32768 is not flagged, and a set flag always comes with 16'h7FFF or 16'h8000 in its word.
- R5: With in_wide=1, all 16 lanes form 8 words. With in_wide=0, only operand bits 63..0 are used and 4 words are formed; out_result[127:64] and out_sat[7:4] are zero, and operand bits 127..64 have no effect on the outputs.
- R6: An operation sampled with in_valid=1 on a clock edge appears with out_valid=1 exactly PIPE_STAGES edges later. out_valid is 0 in every other cycle, and a new operation may enter on every cycle.
- R7: In a cycle with out_valid=0, out_result and out_sat keep the values of the last completed operation.
- R8: While rst_n is low, out_valid, out_result and out_sat are zero, and operations in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| in_wide | input | 1 | 1 selects 128-bit operands, 0 selects 64-bit operands |
| in_opa | input | 128 | Operand A, sixteen unsigned bytes |
| in_opb | input | 128 | Operand B, sixteen signed bytes |
| out_valid | output | 1 | A result is presented this cycle |
| out_result | output | 128 | Eight packed signed 16-bit pair sums |
| out_sat | output | 8 | Per-word clamp-occurred flags |

## Verification
The operand patterns are chosen to separate errors that produce similar outputs. An all-0x80 pair tells an unsigned reading of A from a signed one, and lane values such as 2,3 against 4,5 give a different result if the lanes are paired wrongly or crossed. Sums set to exactly 32767, exactly -32768 and one step past the top bound check both the clamp threshold and the flag, and a vector with only word 0 saturated checks that the flags are kept per word. Narrow-mode vectors carry large values in the upper operand half to show that those bits are ignored. The vectors are streamed back to back, and a single isolated operation, an idle stretch and a reset during a pending operation check timing, hold and clearing.

// File: rtl/mixdot_pkg.sv
package mixdot_pkg;

   // Allowed pipeline depths of the unit.
   localparam int unsigned MD_MIN_STAGES = 1;
   localparam int unsigned MD_MAX_STAGES = 2;

   // Operand width selection.
   typedef enum logic {
      MD_NARROW = 1'b0,
      MD_WIDE   = 1'b1
   } md_width_e;

endpackage

// File: rtl/mixdot_lane_mul.sv
// One byte lane: unsigned element times signed element.
module mixdot_lane_mul #(
   parameter int unsigned ELEM_W = 8,
   localparam int unsigned PW = 2 * ELEM_W
) (
   input  logic [ELEM_W-1:0] u_elem,
   input  logic [ELEM_W-1:0] s_elem,
   output logic [PW-1:0]     prod
);

   logic [PW-1:0] u_ext;
   logic [PW-1:0] s_ext;

   assign u_ext = {{ELEM_W{1'b0}}, u_elem};
   assign s_ext = {{ELEM_W{s_elem[ELEM_W-1]}}, s_elem};

   // The true product fits in PW signed bits, so the product modulo 2^PW is exact.
   assign prod = PW'($signed(u_ext) * $signed(s_ext));

endmodule

// File: rtl/mixdot_pair_sat.sv
// Adds two signed products one bit wider and clamps to the signed PW range.
module mixdot_pair_sat #(
   parameter int unsigned PW = 16
) (
   input  logic [PW-1:0] p_lo,
   input  logic [PW-1:0] p_hi,
   output logic [PW-1:0] word_o,
   output logic          sat_o
);

   logic [PW:0] sum;

   assign sum = {p_lo[PW-1], p_lo} + {p_hi[PW-1], p_hi};

   always_comb begin
      sat_o = sum[PW] ^ sum[PW-1];
      if (sat_o) begin
         word_o = {sum[PW], {(PW-1){~sum[PW]}}};
      end else begin
         word_o = sum[PW-1:0];
      end
   end

endmodule

// File: rtl/mixdot_pair_unit.sv
module mixdot_pair_unit
   import mixdot_pkg::*;
#(
   parameter int unsigned ELEM_W      = 8,
   parameter int unsigned MAX_WORDS   = 8,
   parameter int unsigned PIPE_STAGES = 2,
   localparam int unsigned LANES = 2 * MAX_WORDS,
   localparam int unsigned PW    = 2 * ELEM_W,
   localparam int unsigned OP_W  = LANES * ELEM_W,
   localparam int unsigned RES_W = MAX_WORDS * PW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_wide,
   input  logic [OP_W-1:0]  in_opa,
   input  logic [OP_W-1:0]  in_opb,
   output logic             out_valid,
   output logic [RES_W-1:0] out_result,
   output logic [MAX_WORDS-1:0] out_sat
);

   localparam int unsigned NARROW_LANES = LANES / 2;

   // Elaboration-time parameter checks.
   if (PIPE_STAGES < MD_MIN_STAGES || PIPE_STAGES > MD_MAX_STAGES) begin : g_bad_stages
      $error("mixdot_pair_unit: PIPE_STAGES must be 1 or 2");
   end
   if (ELEM_W < 2) begin : g_bad_elem
      $error("mixdot_pair_unit: ELEM_W must be at least 2");
   end
   if (MAX_WORDS < 2 || (MAX_WORDS % 2) != 0) begin : g_bad_words
      $error("mixdot_pair_unit: MAX_WORDS must be even and at least 2");
   end

   md_width_e mode;
   assign mode = md_width_e'(in_wide);

   logic [LANES-1:0][PW-1:0] prod_c;
   logic [LANES-1:0][PW-1:0] mid_prod;
   logic                     mid_valid;

   // Lane multipliers; upper lanes are forced to zero in narrow mode.
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [ELEM_W-1:0] a_el;
      logic [ELEM_W-1:0] b_el;
      if (i < NARROW_LANES) begin : g_low
         assign a_el = in_opa[i*ELEM_W +: ELEM_W];
         assign b_el = in_opb[i*ELEM_W +: ELEM_W];
      end else begin : g_high
         assign a_el = (mode == MD_WIDE) ? in_opa[i*ELEM_W +: ELEM_W] : '0;
         assign b_el = (mode == MD_WIDE) ? in_opb[i*ELEM_W +: ELEM_W] : '0;
      end
      mixdot_lane_mul #(.ELEM_W(ELEM_W)) u_mul (
         .u_elem(a_el),
         .s_elem(b_el),
         .prod  (prod_c[i])
      );
   end

   // Optional product register between multiply and add stages.
   if (PIPE_STAGES == 2) begin : g_two_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mid_valid <= 1'b0;
            mid_prod  <= '0;
         end else begin
            mid_valid <= in_valid;
            if (in_valid) begin
               mid_prod <= prod_c;
            end
         end
      end
   end else begin : g_one_stage
      assign mid_valid = in_valid;
      assign mid_prod  = prod_c;
   end

   logic [MAX_WORDS-1:0][PW-1:0] word_c;
   logic [MAX_WORDS-1:0]         sat_c;

   for (genvar k = 0; k < MAX_WORDS; k++) begin : g_pair
      mixdot_pair_sat #(.PW(PW)) u_sat (
         .p_lo  (mid_prod[2*k]),
         .p_hi  (mid_prod[2*k+1]),
         .word_o(word_c[k]),
         .sat_o (sat_c[k])
      );
   end

   // Output register; holds its value while no operation completes.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_sat    <= '0;
      end else begin
         out_valid <= mid_valid;
         if (mid_valid) begin
            out_result <= word_c;
            out_sat    <= sat_c;
         end
      end
   end

endmodule

// File: rtl/mixdot_chk.sv
module mixdot_chk #(
   parameter int unsigned MAX_WORDS   = 8,
   parameter int unsigned PW          = 16,
   parameter int unsigned PIPE_STAGES = 2,
   localparam int unsigned RES_W = MAX_WORDS * PW,
   localparam int unsigned HALF_W = MAX_WORDS / 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_wide,
   input logic                 out_valid,
   input logic [RES_W-1:0]     out_result,
   input logic [MAX_WORDS-1:0] out_sat
);

   localparam logic [PW-1:0] MAX_POS = {1'b0, {(PW-1){1'b1}}};
   localparam logic [PW-1:0] MIN_NEG = {1'b1, {(PW-1){1'b0}}};

   logic [PIPE_STAGES-1:0] v_pipe;
   logic [PIPE_STAGES-1:0] w_pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_pipe <= '0;
         w_pipe <= '0;
      end else begin
         v_pipe[0] <= in_valid;
         w_pipe[0] <= in_wide;
         for (int i = 1; i < PIPE_STAGES; i++) begin
            v_pipe[i] <= v_pipe[i-1];
            w_pipe[i] <= w_pipe[i-1];
         end
      end
   end

   // R6: output strobe follows the input strobe by PIPE_STAGES edges
   a_r6_valid_timing: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == v_pipe[PIPE_STAGES-1]);

   // R5: narrow results leave the upper half and upper flags clear
   a_r5_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !w_pipe[PIPE_STAGES-1]) |->
         (out_result[RES_W-1:RES_W/2] == '0 && out_sat[MAX_WORDS-1:HALF_W] == '0));

   // R7: idle cycles keep the last result
   a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_result) && $stable(out_sat)));

   // R8: reset clears the outputs
   a_r8_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_result == '0 && out_sat == '0));

   for (genvar k = 0; k < MAX_WORDS; k++) begin : g_word
      // R4: a set flag carries a clamp value in its word
      a_r4_flag_clamped: assert property (@(posedge clk) disable iff (!rst_n)
         out_sat[k] |-> (out_result[k*PW +: PW] == MAX_POS ||
                         out_result[k*PW +: PW] == MIN_NEG));
   end

endmodule

bind mixdot_pair_unit mixdot_chk #(
   .MAX_WORDS  (MAX_WORDS),
   .PW         (2 * ELEM_W),
   .PIPE_STAGES(PIPE_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_wide   (in_wide),
   .out_valid (out_valid),
   .out_result(out_result),
   .out_sat   (out_sat)
);

// File: tb/mixdot_pair_unit_tb.sv
module mixdot_pair_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int LAT = 2;
   localparam int NV = 14;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_wide = 1'b0;
   logic [127:0] in_opa = '0;
   logic [127:0] in_opb = '0;
   logic         out_valid;
   logic [127:0] out_result;
   logic [7:0]   out_sat;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mixdot_pair_unit #(.ELEM_W(8), .MAX_WORDS(8), .PIPE_STAGES(LAT)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_wide   (in_wide),
      .in_opa    (in_opa),
      .in_opb    (in_opb),
      .out_valid (out_valid),
      .out_result(out_result),
      .out_sat   (out_sat)
   );

   // Stimulus and expected results; word k sits at bits 16k+15..16k.
   localparam logic [127:0] TA [NV] = '{
      {16{8'hFF}},                          // 0  R3 top clamp
      {16{8'hFF}},                          // 1  R3 bottom clamp
      {16{8'h01}},                          // 2  R2 small sums
      {16{8'h02}},                          // 3  R1 negative B
      {16{8'hFF}},                          // 4  R5 narrow clamp
      {16{8'h80}},                          // 5  R2 mid value
      {8{16'hBFFF}},                        // 6  R4 exactly 32767
      {8{16'h01FF}},                        // 7  R4 exactly -32768
      {8{16'hC0FF}},                        // 8  R3 one past top
      {{7{16'h0101}}, 16'hC0FF},            // 9  R4 single word flagged
      {{4{16'hFFFF}}, {4{16'h0101}}},       // 10 R5 upper ignored
      {8{16'h0302}},                        // 11 R2 lane pairing
      {16{8'h80}},                          // 12 R1 A unsigned
      {16{8'hFF}}                           // 13 R1 both large
   };
   localparam logic [127:0] TB [NV] = '{
      {16{8'h7F}}, {16{8'h80}}, {16{8'h01}}, {16{8'hFF}},
      {16{8'h7F}}, {16{8'h40}}, {8{16'h027F}}, {8{16'h8080}},
      {8{16'h027F}}, {{7{16'h0101}}, 16'h027F},
      {{4{16'h7F7F}}, {4{16'h0101}}}, {8{16'h0504}},
      {16{8'h80}}, {16{8'hFE}}
   };
   localparam bit TW [NV] = '{1, 1, 1, 1, 0, 1, 1, 1, 1, 1, 0, 1, 1, 1};
   localparam logic [127:0] TR [NV] = '{
      {8{16'h7FFF}}, {8{16'h8000}}, {8{16'h0002}}, {8{16'hFFFC}},
      {{4{16'h0000}}, {4{16'h7FFF}}}, {8{16'h4000}}, {8{16'h7FFF}},
      {8{16'h8000}}, {8{16'h7FFF}}, {{7{16'h0002}}, 16'h7FFF},
      {{4{16'h0000}}, {4{16'h0002}}}, {8{16'h0017}}, {8{16'h8000}},
      {8{16'hFC04}}
   };
   localparam logic [7:0] TF [NV] = '{
      8'hFF, 8'hFF, 8'h00, 8'h00, 8'h0F, 8'h00, 8'h00,
      8'h00, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00
   };
   localparam int TT [NV] = '{3, 3, 2, 1, 5, 2, 4, 4, 3, 4, 5, 2, 1, 1};

   task automatic chk(input bit ok, input int req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL R%0d %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic drive(input int idx, input bit vld);
      in_valid = vld;
      in_wide  = TW[idx];
      in_opa   = TA[idx];
      in_opb   = TB[idx];
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      $display("FAIL R6 watchdog expired act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R8: reset state
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, 8, "reset out_valid", 128'(out_valid), 0);
      chk(out_result == '0, 8, "reset result", out_result, 0);
      chk(out_sat == '0, 8, "reset flags", 128'(out_sat), 0);
      rst_n = 1'b1;

      // Table walk, streamed back to back (R6 throughput)
      for (int n = 0; n < NV + LAT; n++) begin
         @(negedge clk);
         if (n >= LAT) begin
            int j;
            j = n - LAT;
            chk(out_valid == 1'b1, 6, $sformatf("vec %0d out_valid", j), 128'(out_valid), 1);
            chk(out_result == TR[j], TT[j], $sformatf("vec %0d result", j), out_result, TR[j]);
            chk(out_sat == TF[j], 4, $sformatf("vec %0d flags", j), 128'(out_sat), 128'(TF[j]));
         end else begin
            chk(out_valid == 1'b0, 6, "pre-result out_valid", 128'(out_valid), 0);
         end
         if (n < NV) drive(n, 1'b1);
         else in_valid = 1'b0;
      end

      // R7: idle with changing operands keeps the last result
      in_opa = '1;
      in_opb = {16{8'h7F}};
      in_wide = 1'b1;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, 7, "idle out_valid", 128'(out_valid), 0);
      chk(out_result == TR[NV-1], 7, "idle hold result", out_result, TR[NV-1]);
      chk(out_sat == TF[NV-1], 7, "idle hold flags", 128'(out_sat), 128'(TF[NV-1]));

      // R6: isolated operation, exact latency and single-cycle strobe
      @(negedge clk);
      drive(2, 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      for (int d = 1; d < LAT; d++) begin
         chk(out_valid == 1'b0, 6, "early out_valid", 128'(out_valid), 0);
         @(negedge clk);
      end
      chk(out_valid == 1'b1, 6, "on-time out_valid", 128'(out_valid), 1);
      chk(out_result == TR[2], 2, "isolated result", out_result, TR[2]);
      @(negedge clk);
      chk(out_valid == 1'b0, 6, "strobe one cycle", 128'(out_valid), 0);

      // R8: reset while an operation is in flight
      drive(0, 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      chk(out_valid == 1'b0, 8, "mid reset out_valid", 128'(out_valid), 0);
      chk(out_result == '0, 8, "mid reset result", out_result, 0);
      chk(out_sat == '0, 8, "mid reset flags", 128'(out_sat), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int d = 0; d < LAT + 1; d++) begin
         @(negedge clk);
         chk(out_valid == 1'b0, 8, "dropped op stays gone", 128'(out_valid), 0);
      end
      chk(out_result == '0, 8, "result after reset", out_result, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule